// File: doc/BRIEF.md
# Hardware-Limit Timer Mode Controller

This block is an up-counting timer with a programmable period and a single external control input. A five-bit mode code chooses how that input, together with a software enable bit, starts, resets, gates and stops the counter. The upper two mode bits select a family. The free-running family wraps at the period and may be gated or reset by the external input. The one-shot family runs once and then drops the enable. The monostable family runs once per qualifying edge and keeps the enable set, so that the next edge fires it again. The lower three bits select the edge or level behaviour within the family.

The external input is brought into the timer clock domain through a synchronizer, and edges are found by comparing successive synchronized samples. A debug flag freezes the synchronized view of the input, so that it neither gates, resets nor starts the counter while the flag is high. The enable output shows the live state of the enable: it is set by a rising software enable and is cleared by a low software enable or by the end of a one-shot run.

Top module: `limit_timer`

## Requirements
- R1: After a synchronous reset, the count output is 0, the enable output is 0 and the match pulse is 0.
- R2: In mode 00000 the counter increments once per clock while the enable is set and holds its value while it is clear. When the count equals the period value, the match pulse is high for that cycle and the next clock loads 0. One full period therefore lasts period+1 clocks.
- R3: Mode 00001 counts only while the enable is set and the external input is high. Mode 00010 counts only while the enable is set and the external input is low.
- R4: With the enable set, modes 00011, 00100 and 00101 clear the counter on any edge, a rising edge and a falling edge of the external input respectively. The other edge direction has no effect in 00100 and 00101.
- R5: Mode 00110 holds the counter at 0 while the external input is low, and mode 00111 holds it at 0 while the input is high. The counter counts when the enable is set and the input is at the other level.
- R6: In mode 01000 the counter runs while the enable is set. The clock after a period match loads 0 and clears the enable output. The enable output stays clear while the software enable stays high, and it is set again only by a new low-to-high transition of the software enable.
- R7: Modes 01001, 01010 and 01011 start a one-shot run on a rising, a falling or any edge of the external input respectively, and only while the enable is set. The run ends as in R6.
- R8: The one-shot modes with a hardware reset start and reset as follows: 01100 starts on a rising edge and is reset by a rising edge; 01101 starts on a falling edge and is reset by a falling edge; 01110 starts on a rising edge and is held at 0 while the input is low; 01111 starts on a falling edge and is held at 0 while the input is high. A reset during a run clears the count, and the run continues.
- R9: Modes 10001, 10010 and 10011 start a run on a rising, a falling or any edge while the enable is set. Edges during a run are ignored. The clock after a period match loads 0 and stops the counter, while the enable output stays set, so that the next qualifying edge starts a new run.
- R10: Mode 10110 counts while the input is high and holds the counter at 0 while it is low. Mode 10111 is the same with the levels swapped. In both modes the clock after a period match loads 0 and clears the enable output.
- R11: The codes 10000, 10100, 10101 and every code with the upper bits 11 hold the counter at 0.
- R12: An edge-started mode needs a qualifying edge that occurs while the enable is set. An edge that arrived while the enable was clear does not start the counter once the enable is set.
- R13: While the debug flag is high, changes of the external input neither reset, gate nor start the counter.
- R14: An external input change takes effect at the third rising clock edge after it: two synchronizer stages, then the counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| onIn | input | 1 | Software enable bit |
| modeSel | input | 5 | Mode code; the upper two bits select the family |
| periodVal | input | CNT_W | Period (match) value |
| extIn | input | 1 | External gate, reset or start input, asynchronous |
| dbgMode | input | 1 | Debug flag; freezes the view of the external input |
| cntOut | output | CNT_W | Current count |
| matchPulse | output | 1 | High during a running cycle whose count equals the period |
| onOut | output | 1 | Live enable state |

## Verification
Each family is driven with slow level changes and isolated edges on the external input, with the period kept small so that wraps and run ends happen inside short windows. In edge-reset modes the opposite edge is applied as well, to separate edge-direction decoding from plain level sensing. Running each edge-started mode with an edge that occurs before the enable separates the one-shot and monostable start qualification from level gating. The count and enable are sampled cycle-exactly around a period match, which separates a one-shot (enable cleared), a monostable (enable kept, retriggered by a later edge) and a free-running wrap.

// File: rtl/limit_timer_pkg.sv
package limit_timer_pkg;

  typedef enum logic [1:0] {
    FAM_FREE    = 2'b00,
    FAM_ONESHOT = 2'b01,
    FAM_MONO    = 2'b10,
    FAM_RSVD    = 2'b11
  } family_e;

  // strobes from control to the counter datapath; clr wins over inc
  typedef struct packed {
    logic clr;
    logic inc;
  } cntCtl_t;

endpackage

// File: rtl/limit_timer_sync.sv
module limit_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic extIn,
  input  logic dbgMode,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic prevLvl;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= extIn;
  end

  generate
    for (genvar i = 1; i < STAGES - 1; i++) begin : g_mid
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  // last stage is frozen in debug so the control sees no change
  always_ff @(posedge clk) begin
    if (rst) begin
      chain[STAGES-1] <= 1'b0;
      prevLvl         <= 1'b0;
    end else begin
      if (!dbgMode) chain[STAGES-1] <= chain[STAGES-2];
      prevLvl <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prevLvl & ~dbgMode;
  assign fall = ~lvl & prevLvl & ~dbgMode;

endmodule

// File: rtl/limit_timer_count.sv
module limit_timer_count
  import limit_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  cntCtl_t          ctl,
  input  logic [CNT_W-1:0] periodVal,
  output logic [CNT_W-1:0] cnt,
  output logic             atLimit
);
  always_ff @(posedge clk) begin
    if (rst || ctl.clr) cnt <= '0;
    else if (ctl.inc)   cnt <= cnt + CNT_W'(1);
  end

  assign atLimit = (cnt == periodVal);

  // R2: an increment strobe advances the count by exactly one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (ctl.inc && !ctl.clr) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

  // R2: a clear strobe lands the count at zero
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    ctl.clr |=> (cnt == '0));

endmodule

// File: rtl/limit_timer_ctrl.sv
module limit_timer_ctrl
  import limit_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             onIn,
  input  logic [4:0]       modeSel,
  input  logic             atLimit,
  input  logic [CNT_W-1:0] cnt,
  input  logic             lvl,
  input  logic             rise,
  input  logic             fall,
  input  logic             dbgMode,
  output cntCtl_t          ctl,
  output logic             matchPulse,
  output logic             onOut
);
  family_e    fam;
  logic [2:0] sub;
  logic onReg, onPrev, started, startedNext;
  logic run, hwRst, startEvt, useStarted, clrOnEnd, rsvd;
  logic matchHit, hwClr, anyEdge;

  assign fam     = family_e'(modeSel[4:3]);
  assign sub     = modeSel[2:0];
  assign anyEdge = rise | fall;

  always_comb begin
    run = 1'b0; hwRst = 1'b0; startEvt = 1'b0;
    useStarted = 1'b0; clrOnEnd = 1'b0; rsvd = 1'b0;
    unique case (fam)
      FAM_FREE: begin
        case (sub)
          3'd0: run = onReg;
          3'd1: run = onReg & lvl;
          3'd2: run = onReg & ~lvl;
          3'd3: begin run = onReg; hwRst = onReg & anyEdge; end
          3'd4: begin run = onReg; hwRst = onReg & rise; end
          3'd5: begin run = onReg; hwRst = onReg & fall; end
          3'd6: begin run = onReg & lvl;  hwRst = ~lvl; end
          default: begin run = onReg & ~lvl; hwRst = lvl; end
        endcase
      end
      FAM_ONESHOT: begin
        clrOnEnd   = 1'b1;
        useStarted = (sub != 3'd0);
        case (sub)
          3'd0: run = onReg;
          3'd1: startEvt = rise;
          3'd2: startEvt = fall;
          3'd3: startEvt = anyEdge;
          3'd4: begin startEvt = rise; hwRst = started & rise; end
          3'd5: begin startEvt = fall; hwRst = started & fall; end
          3'd6: begin startEvt = rise; hwRst = ~lvl; end
          default: begin startEvt = fall; hwRst = lvl; end
        endcase
      end
      FAM_MONO: begin
        case (sub)
          3'd1: begin useStarted = 1'b1; startEvt = rise; end
          3'd2: begin useStarted = 1'b1; startEvt = fall; end
          3'd3: begin useStarted = 1'b1; startEvt = anyEdge; end
          3'd6: begin clrOnEnd = 1'b1; run = onReg & lvl;  hwRst = ~lvl; end
          3'd7: begin clrOnEnd = 1'b1; run = onReg & ~lvl; hwRst = lvl; end
          default: rsvd = 1'b1;
        endcase
      end
      default: rsvd = 1'b1;
    endcase
    if (useStarted) run = onReg & started;
  end

  assign matchHit   = run & atLimit;
  assign matchPulse = matchHit & ~hwRst;
  assign hwClr      = matchPulse & clrOnEnd;

  assign ctl.clr = rsvd | hwRst | matchHit;
  assign ctl.inc = run & ~ctl.clr;

  always_comb begin
    startedNext = started;
    if (!useStarted || !onReg)  startedNext = 1'b0;
    else if (matchPulse)        startedNext = 1'b0;
    else if (startEvt)          startedNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      onReg   <= 1'b0;
      onPrev  <= 1'b0;
      started <= 1'b0;
    end else begin
      onPrev  <= onIn;
      onReg   <= onIn & (onReg | ~onPrev) & ~hwClr;
      started <= startedNext;
    end
  end

  assign onOut = onReg;

  // R11: reserved codes leave the counter at zero
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (modeSel[4:3] == 2'b11 || modeSel == 5'b10000) |=> (cnt == '0));

  // R6: end of a one-shot run drops the enable
  a_r6_end_clears_on: assert property (@(posedge clk) disable iff (rst)
    (modeSel[4:3] == 2'b01 && matchPulse) |=> !onOut);

  // R9: monostable end keeps the enable while software holds it
  a_r9_mono_keeps_on: assert property (@(posedge clk) disable iff (rst)
    (modeSel[4:3] == 2'b10 && modeSel[2] == 1'b0 && matchPulse && onIn)
      |=> onOut);

  // R2: free-running wrap at the period value
  a_r2_free_wrap: assert property (@(posedge clk) disable iff (rst)
    (modeSel[4:3] == 2'b00 && matchPulse) |=> (cnt == '0));

  // R13: the synchronized level is frozen in debug
  a_r13_dbg_frozen: assert property (@(posedge clk) disable iff (rst)
    dbgMode |=> $stable(lvl));

endmodule

// File: rtl/limit_timer.sv
module limit_timer
  import limit_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             onIn,
  input  logic [4:0]       modeSel,
  input  logic [CNT_W-1:0] periodVal,
  input  logic             extIn,
  input  logic             dbgMode,
  output logic [CNT_W-1:0] cntOut,
  output logic             matchPulse,
  output logic             onOut
);
  logic    lvl, rise, fall, atLimit;
  cntCtl_t ctl;

  limit_timer_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .extIn(extIn), .dbgMode(dbgMode),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  limit_timer_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .onIn(onIn), .modeSel(modeSel),
    .atLimit(atLimit), .cnt(cntOut), .lvl(lvl), .rise(rise), .fall(fall),
    .dbgMode(dbgMode), .ctl(ctl), .matchPulse(matchPulse), .onOut(onOut)
  );

  limit_timer_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst(rst), .ctl(ctl), .periodVal(periodVal),
    .cnt(cntOut), .atLimit(atLimit)
  );

endmodule

// File: tb/limit_timer_tb_top.sv
`timescale 1ns/1ps
module limit_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       onIn = 1'b0;
  logic [4:0] modeSel = '0;
  logic [7:0] periodVal = 8'd20;
  logic       extIn = 1'b0;
  logic       dbgMode = 1'b0;
  logic [7:0] cntOut;
  logic       matchPulse, onOut;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  limit_timer dut_i (
    .clk(clk), .rst(rst), .onIn(onIn), .modeSel(modeSel),
    .periodVal(periodVal), .extIn(extIn), .dbgMode(dbgMode),
    .cntOut(cntOut), .matchPulse(matchPulse), .onOut(onOut)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reset with a mode, an input level and a period, then let the sync settle
  task automatic setup(input logic [4:0] m, input logic e, input logic [7:0] p);
    rst = 1'b1; onIn = 1'b0; dbgMode = 1'b0;
    modeSel = m; extIn = e; periodVal = p;
    step(2);
    rst = 1'b0;
    step(3);
  endtask

  task automatic t_reset();
    setup(5'b00000, 1'b0, 8'd5);
    chk("R1 count", cntOut, 0);
    chk("R1 enable", onOut, 0);
    chk("R1 match", matchPulse, 0);
  endtask

  task automatic t_soft_gate();
    setup(5'b00000, 1'b0, 8'd5);
    onIn = 1'b1;
    step(3); chk("R2 counting", cntOut, 2);
    step(3); chk("R2 at period", cntOut, 5);
    chk("R2 match pulse", matchPulse, 1);
    step(1); chk("R2 wrap", cntOut, 0);
    chk("R2 pulse gone", matchPulse, 0);
    onIn = 1'b0;
    step(1); chk("R2 last step", cntOut, 1);
    step(3); chk("R2 hold when off", cntOut, 1);
    chk("R2 enable off", onOut, 0);
  endtask

  task automatic t_hw_gate();
    setup(5'b00001, 1'b0, 8'd20);
    onIn = 1'b1;
    step(5); chk("R3 gate low blocks", cntOut, 0);
    extIn = 1'b1;
    step(4); chk("R3 gate high counts", cntOut, 2);
    extIn = 1'b0;
    step(4); chk("R3 gate closes", cntOut, 4);
    setup(5'b00010, 1'b1, 8'd20);
    onIn = 1'b1;
    step(4); chk("R3 active-low blocked", cntOut, 0);
    extIn = 1'b0;
    step(5); chk("R3 active-low counts", cntOut, 3);
  endtask

  task automatic t_edge_reset();
    setup(5'b00100, 1'b0, 8'd20);
    onIn = 1'b1;
    step(7); chk("R4 before edge", cntOut, 6);
    extIn = 1'b1;
    step(2); chk("R14 not yet reset", cntOut, 8);
    step(1); chk("R4 rise resets", cntOut, 0);
    step(2); chk("R4 counts again", cntOut, 2);
    extIn = 1'b0;
    step(5); chk("R4 fall ignored", cntOut, 7);
    setup(5'b00011, 1'b0, 8'd20);
    onIn = 1'b1;
    step(4); chk("R4 any-edge pre", cntOut, 3);
    extIn = 1'b1;
    step(3); chk("R4 any-edge rise", cntOut, 0);
    extIn = 1'b0;
    step(3); chk("R4 any-edge fall", cntOut, 0);
    setup(5'b00101, 1'b1, 8'd20);
    onIn = 1'b1;
    step(4); chk("R4 fall-mode pre", cntOut, 3);
    extIn = 1'b0;
    step(3); chk("R4 fall resets", cntOut, 0);
  endtask

  task automatic t_level_reset();
    setup(5'b00110, 1'b0, 8'd20);
    onIn = 1'b1;
    step(6); chk("R5 low holds zero", cntOut, 0);
    extIn = 1'b1;
    step(5); chk("R5 high counts", cntOut, 3);
    extIn = 1'b0;
    step(3); chk("R5 low resets", cntOut, 0);
    setup(5'b00111, 1'b1, 8'd20);
    onIn = 1'b1;
    step(4); chk("R5 high holds zero", cntOut, 0);
  endtask

  task automatic t_oneshot_soft();
    setup(5'b01000, 1'b0, 8'd3);
    onIn = 1'b1;
    step(1); chk("R6 enable set", onOut, 1);
    step(3); chk("R6 at period", cntOut, 3);
    chk("R6 match pulse", matchPulse, 1);
    step(1); chk("R6 stops at zero", cntOut, 0);
    chk("R6 enable cleared", onOut, 0);
    step(4); chk("R6 stays stopped", cntOut, 0);
    chk("R6 enable stays clear", onOut, 0);
    onIn = 1'b0; step(1);
    onIn = 1'b1;
    step(3); chk("R6 rearm by toggle", cntOut, 2);
  endtask

  task automatic t_oneshot_edge();
    setup(5'b01001, 1'b0, 8'd4);
    onIn = 1'b1;
    step(4); chk("R7 waits for edge", cntOut, 0);
    extIn = 1'b1;
    step(3); chk("R7 started", cntOut, 0);
    step(2); chk("R7 running", cntOut, 2);
    step(2); chk("R7 match", matchPulse, 1);
    step(1); chk("R7 end count", cntOut, 0);
    chk("R7 end enable", onOut, 0);
  endtask

  task automatic t_edge_needs_on();
    setup(5'b01001, 1'b0, 8'd20);
    extIn = 1'b1;
    step(4);
    onIn = 1'b1;
    step(6); chk("R12 stale edge ignored", cntOut, 0);
    extIn = 1'b0; step(3);
    extIn = 1'b1;
    step(5); chk("R12 fresh edge starts", cntOut, 2);
  endtask

  task automatic t_oneshot_reset();
    setup(5'b01100, 1'b0, 8'd20);
    onIn = 1'b1;
    step(2);
    extIn = 1'b1;
    step(3); chk("R8 rise starts", cntOut, 0);
    step(4); chk("R8 running", cntOut, 4);
    extIn = 1'b0;
    step(3); chk("R8 fall no reset", cntOut, 7);
    extIn = 1'b1;
    step(3); chk("R8 rise resets", cntOut, 0);
    step(2); chk("R8 keeps running", cntOut, 2);
    setup(5'b01110, 1'b0, 8'd20);
    onIn = 1'b1;
    step(2);
    extIn = 1'b1;
    step(5); chk("R8 level mode runs", cntOut, 2);
    extIn = 1'b0;
    step(3); chk("R8 low resets", cntOut, 0);
    step(3); chk("R8 held low", cntOut, 0);
  endtask

  task automatic t_mono();
    setup(5'b10001, 1'b0, 8'd3);
    onIn = 1'b1;
    step(2);
    extIn = 1'b1;
    step(3); chk("R9 started", cntOut, 0);
    step(3); chk("R9 match", matchPulse, 1);
    step(1); chk("R9 stop count", cntOut, 0);
    chk("R9 enable kept", onOut, 1);
    step(3); chk("R9 stays stopped", cntOut, 0);
    extIn = 1'b0; step(3);
    extIn = 1'b1;
    step(5); chk("R9 retrigger", cntOut, 2);
    chk("R9 enable still set", onOut, 1);
  endtask

  task automatic t_level_oneshot();
    setup(5'b10110, 1'b0, 8'd3);
    onIn = 1'b1;
    step(4); chk("R10 low holds", cntOut, 0);
    extIn = 1'b1;
    step(5); chk("R10 match", matchPulse, 1);
    chk("R10 at period", cntOut, 3);
    step(1); chk("R10 enable cleared", onOut, 0);
    step(3); chk("R10 stopped", cntOut, 0);
    setup(5'b10111, 1'b0, 8'd20);
    onIn = 1'b1;
    step(5); chk("R10 low-start runs", cntOut, 4);
  endtask

  task automatic t_reserved();
    setup(5'b11000, 1'b0, 8'd20);
    onIn = 1'b1;
    step(6); chk("R11 code 11000", cntOut, 0);
    setup(5'b10000, 1'b0, 8'd20);
    onIn = 1'b1;
    step(6); chk("R11 code 10000", cntOut, 0);
    setup(5'b10101, 1'b0, 8'd20);
    onIn = 1'b1; extIn = 1'b1;
    step(6); chk("R11 code 10101", cntOut, 0);
  endtask

  task automatic t_debug();
    setup(5'b00100, 1'b0, 8'd20);
    onIn = 1'b1;
    step(4); chk("R13 pre debug", cntOut, 3);
    dbgMode = 1'b1; extIn = 1'b1;
    step(5); chk("R13 edge ignored", cntOut, 8);
  endtask

  initial begin
    t_reset();
    t_soft_gate();
    t_hw_gate();
    t_edge_reset();
    t_level_reset();
    t_oneshot_soft();
    t_oneshot_edge();
    t_edge_needs_on();
    t_oneshot_reset();
    t_mono();
    t_level_oneshot();
    t_reserved();
    t_debug();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule